// File: doc/BRIEF.md
# Charge-Balance ADC Control Sequencer

This block is the digital controller of a charge-balancing integrating converter. A clock-enable tick stands in for the conversion clock. A comparator bit reports whether the integrator has crossed its threshold. The block steers two analog switches. The first switches the reference current into the integrator. The second grounds the converter input for offset storage. The analog integrator, the comparator, the reference source and any display logic sit outside the block.

The sequencer alternates between two phases, auto-zero and measurement. During auto-zero the input is grounded and the reference is held off, so the offset capacitor can settle. During measurement a signed up/down counter moves once per tick. It counts up when only the input is charging the integrator and down when the reference is discharging it. On every tick the reference switch follows the comparator, so the integrator swings back and forth around the threshold. When the interval ends, the net count is latched as a signed result and a one-cycle valid strobe is raised. The reference is then forced off and auto-zero starts again.

The measurement length is a parameter in ticks. Its default is 2048 ticks, which at a 20.48 kHz tick is 100 ms: a whole number of periods at both 50 Hz and 60 Hz, so line-frequency pickup cancels in the net count.

Top module: `cb_adc_seq`

## Requirements
- R1: While rst_ni is low and after it is released, az_o is 1, ref_on_o is 0, valid_o is 0 and result_o is 0.
- R2: After reset, and after each measurement ends, az_o stays 1 for exactly AZ_TICKS ticks. It then stays 0 for exactly MEAS_TICKS ticks, and the cycle repeats.
- R3: comp_i passes through a two-flop synchroniser. A comp_i value of 1 means the threshold has been crossed. On each measurement tick other than the last, ref_on_o takes the synchronised comparator value seen at that tick. A comparator change made only one cycle before a tick has not yet reached the synchroniser output, so the tick still uses the old value.
- R4: ref_on_o is 0 whenever az_o is 1.
- R5: The net count is cleared when measurement starts. Each measurement tick adds +1 if ref_on_o was 0 before the tick and −1 if it was 1.
- R6: On the last measurement tick, result_o is loaded with the net count including that tick. valid_o is 1 for exactly one cycle, in the cycle after that tick. result_o then holds until the next measurement ends.
- R7: The result is two's complement of width $clog2(MEAS_TICKS+1)+1 and always lies within ±MEAS_TICKS.
- R8: If comp_i is held at 0 for a whole measurement, the result is +MEAS_TICKS. If it is held at 1, the result is 2−MEAS_TICKS: the first tick counts up, and every later tick counts down.
- R9: While tick_i is 0, comp_i activity changes neither ref_on_o, az_o nor result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Conversion clock enable, one cycle per tick |
| comp_i | input | 1 | Integrator threshold comparator, asynchronous |
| az_o | output | 1 | Auto-zero switch: input grounded |
| ref_on_o | output | 1 | Reference current switch |
| result_o | output | $clog2(MEAS_TICKS+1)+1 | Signed net count of the last measurement |
| valid_o | output | 1 | One-cycle strobe when result_o is loaded |

## Verification
The assertions check properties that must hold on every cycle:
- the reference stays off during auto-zero;
- the reference and the phase change only on a tick;
- the strobe lasts one cycle and coincides with the return to auto-zero;
- the result holds between strobes;
- the running count is zero when measurement starts and stays within ±MEAS_TICKS;
- the phase counter never passes its limit.

Only the bench scenarios can show that the net count is correct. The bench checks it for constant comparator levels, for a closed-loop integrator model and for an alternating pattern. It also checks the exact phase lengths and the synchroniser latency at a tick that arrives only one cycle after the comparator changes.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic {
    PH_AZ   = 1'b0,
    PH_MEAS = 1'b1
  } phase_e;
endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("cb_sync: STAGES must be at least 2");
  end
endmodule

// File: rtl/cb_phase_timer.sv
module cb_phase_timer
  import cb_pkg::*;
#(
  parameter int unsigned AZ_TICKS   = 1024,
  parameter int unsigned MEAS_TICKS = 2048
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   az_end_o,
  output logic   meas_end_o
);
  localparam int unsigned MAXT = (AZ_TICKS > MEAS_TICKS) ? AZ_TICKS : MEAS_TICKS;
  localparam int unsigned PW   = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [PW-1:0] AZ_LAST   = PW'(AZ_TICKS - 1);
  localparam logic [PW-1:0] MEAS_LAST = PW'(MEAS_TICKS - 1);

  phase_e        phase_q;
  logic [PW-1:0] cnt_q;

  assign az_end_o   = tick_i && (phase_q == PH_AZ)   && (cnt_q == AZ_LAST);
  assign meas_end_o = tick_i && (phase_q == PH_MEAS) && (cnt_q == MEAS_LAST);
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else if (az_end_o) begin
      phase_q <= PH_MEAS;
      cnt_q   <= '0;
    end else if (meas_end_o) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R2: position within a phase never passes that phase's length
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_AZ) ? (cnt_q <= AZ_LAST) : (cnt_q <= MEAS_LAST));

  // R9: phase moves only on a tick
  p_phase_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));

  initial begin
    if (AZ_TICKS < 1)   $error("cb_phase_timer: AZ_TICKS must be at least 1");
    if (MEAS_TICKS < 2) $error("cb_phase_timer: MEAS_TICKS must be at least 2");
  end
endmodule

// File: rtl/cb_updown.sv
module cb_updown
  import cb_pkg::*;
#(
  parameter int unsigned MEAS_TICKS = 2048,
  parameter int unsigned CW         = $clog2(MEAS_TICKS + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  phase_e        phase_i,
  input  logic          az_end_i,
  input  logic          meas_end_i,
  input  logic          comp_i,
  output logic          ref_on_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] result_o,
  output logic          valid_o
);
  localparam logic signed [CW-1:0] LIM = CW'(MEAS_TICKS);

  logic signed [CW-1:0] count_q, step, count_nx;
  logic [CW-1:0]        result_q;
  logic                 ref_q, valid_q;
  logic                 meas_tick;

  assign meas_tick = tick_i && (phase_i == PH_MEAS);
  assign step      = ref_q ? {CW{1'b1}} : CW'(1);
  assign count_nx  = count_q + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      result_q <= '0;
      ref_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (az_end_i) begin
        count_q <= '0;
        ref_q   <= 1'b0;
      end else if (meas_end_i) begin
        count_q  <= count_nx;
        result_q <= count_nx;
        valid_q  <= 1'b1;
        ref_q    <= 1'b0;
      end else if (meas_tick) begin
        count_q <= count_nx;
        ref_q   <= comp_i;
      end
    end
  end

  assign ref_on_o = ref_q;
  assign count_o  = count_q;
  assign result_o = result_q;
  assign valid_o  = valid_q;

  // R3: reference switch moves only on a tick
  p_ref_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ref_q));

  // R6: strobe lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R6: result holds between strobes
  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(result_q));

  // R7: running count stays within the interval length
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q <= LIM) && (count_q >= -LIM));
endmodule

// File: rtl/cb_adc_seq.sv
module cb_adc_seq
  import cb_pkg::*;
#(
  parameter int unsigned AZ_TICKS   = 1024,
  parameter int unsigned MEAS_TICKS = 2048,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MEAS_TICKS + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          comp_i,
  output logic          az_o,
  output logic          ref_on_o,
  output logic [CW-1:0] result_o,
  output logic          valid_o
);
  logic          comp_s;
  phase_e        phase;
  logic          az_end, meas_end;
  logic [CW-1:0] count;

  cb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (comp_i),
    .q_o   (comp_s)
  );

  cb_phase_timer #(.AZ_TICKS(AZ_TICKS), .MEAS_TICKS(MEAS_TICKS)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .phase_o   (phase),
    .az_end_o  (az_end),
    .meas_end_o(meas_end)
  );

  cb_updown #(.MEAS_TICKS(MEAS_TICKS), .CW(CW)) i_updown (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .phase_i   (phase),
    .az_end_i  (az_end),
    .meas_end_i(meas_end),
    .comp_i    (comp_s),
    .ref_on_o  (ref_on_o),
    .count_o   (count),
    .result_o  (result_o),
    .valid_o   (valid_o)
  );

  assign az_o = (phase == PH_AZ);

  // R4: no reference current while the input is grounded
  p_ref_off_az_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    az_o |-> !ref_on_o);

  // R6: strobe comes with the return to auto-zero
  p_valid_az_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> az_o);

  // R5: count starts from zero in each measurement
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(az_o) |-> (count == '0));
endmodule

// File: tb/test_cb_adc_seq.sv
module test_cb_adc_seq;
  localparam int AZ   = 5;
  localparam int MEAS = 16;
  localparam int CW   = $clog2(MEAS + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, comp = 1'b0;
  logic az, ref_on, valid;
  logic [CW-1:0] result;

  int checks = 0, errors = 0;
  int exp_q[$];
  int last_exp = 0;
  bit ref_m = 1'b0;
  int cnt_m = 0;
  bit done = 1'b0;
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  cb_adc_seq #(.AZ_TICKS(AZ), .MEAS_TICKS(MEAS)) i_cb_adc_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .comp_i(comp),
    .az_o(az), .ref_on_o(ref_on), .result_o(result), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // comp settles through the synchroniser before the tick (or not, if fast)
  task automatic pulse_tick(input bit c, input bit fast);
    comp = c;
    if (!fast) repeat (3) @(negedge clk);
    else       @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic az_phase();
    for (int i = 0; i < AZ; i++) begin
      chk("R2 az before tick", int'(az), 1);
      pulse_tick(bit'(i & 1), 1'b0);
      chk("R4 ref off in auto-zero", int'(ref_on), 0);
      chk("R6 result held", $signed(result), last_exp);
    end
    chk("R2 az low after AZ_TICKS", int'(az), 0);
  endtask

  // one measurement tick: c is comparator, prev_c is what the sync still holds
  task automatic meas_tick(input int i, input bit c, input bit prev_c, input bit fast);
    cnt_m += ref_m ? -1 : 1;
    if (i == MEAS - 1) begin
      ref_m = 1'b0;
      exp_q.push_back(cnt_m);
      last_exp = cnt_m;
    end else begin
      ref_m = fast ? prev_c : c;
    end
    pulse_tick(c, fast);
    chk(fast ? "R3 sync latency" : "R3 ref follows comp", int'(ref_on), int'(ref_m));
    chk("R2 phase", int'(az), (i == MEAS - 1) ? 1 : 0);
  endtask

  // mode 0: all 0, 1: all 1, 2: integrator model, 3: alternating with fast tick and idle
  task automatic run_meas(input int mode);
    int v = 0;
    bit c, pc;
    pc = comp;
    cnt_m = 0;
    ref_m = 1'b0;
    for (int i = 0; i < MEAS; i++) begin
      case (mode)
        0: c = 1'b0;
        1: c = 1'b1;
        2: begin
             v += 3 - (ref_on ? 8 : 0);
             c = (v >= 2);
           end
        default: c = bit'(i & 1);
      endcase
      if (mode == 3 && i == 8) begin
        // R9: comparator toggling without tick changes nothing
        logic r0;
        logic [CW-1:0] res0;
        r0 = ref_on;
        res0 = result;
        for (int k = 0; k < 10; k++) begin
          comp = ~comp;
          @(negedge clk);
          chk("R9 ref stable without tick", int'(ref_on), int'(r0));
          chk("R9 az stable without tick", int'(az), 0);
        end
        chk("R9 result stable without tick", int'(result), int'(res0));
        comp = pc;
        repeat (3) @(negedge clk);
      end
      meas_tick(i, c, pc, (mode == 3 && i == 5));
      pc = c;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (exp_q.size() == 0) chk("R6 unexpected valid", 1, 0);
        else chk("R6 R7 result", $signed(result), exp_q.pop_front());
        chk("R6 single-cycle valid", int'(prev_valid), 0);
      end
    end
    prev_valid = valid;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 az in reset", int'(az), 1);
    chk("R1 ref in reset", int'(ref_on), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 az after reset", int'(az), 1);
    chk("R1 ref after reset", int'(ref_on), 0);
    chk("R1 valid after reset", int'(valid), 0);
    chk("R1 result after reset", int'(result), 0);

    az_phase(); run_meas(0);
    chk("R8 all-low result", last_exp, MEAS);
    az_phase(); run_meas(1);
    chk("R8 all-high result", last_exp, 2 - MEAS);
    az_phase(); run_meas(2);
    az_phase(); run_meas(3);
    az_phase();
    repeat (4) @(negedge clk);
    chk("R6 all results seen", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule